// File: doc/BRIEF.md
# Multi-UART Interrupt and Address-Decode Hub

This block is the memory-mapped front end for a bank of serial port cores. A 32-bit register bus reaches it through a simple select/write-enable interface. Addresses below 0x1000 hit a small global bank. That bank holds an identification word, the port count, a live interrupt status word, an interrupt enable mask and a wake enable mask. Addresses from 0x1000 upward are split into fixed 0x200-byte windows, one per port. An access that lands in the register half of an existing port's window is forwarded to that port as a one-hot select with a local offset and strobes.

Each port supplies one interrupt level. The hub gathers these levels into its status word and drives one registered, level-sensitive interrupt output from the status word and the enable mask. Both masks change only through paired set and clear addresses, so software never needs a read-modify-write. The upper half of each port window is a placeholder for DMA registers and is inert. After an asynchronous reset, the hub gives the ports a reset pulse.

Top module: `uart_irq_hub`

## Requirements
- R1: A read of offset 0x000 returns 0x00070002, and a read of offset 0x004 returns the NPORT parameter (1 to 16).
- R2: A write to offset 0x00C ORs the write data into the 32-bit enable mask. A read of 0x00C returns the mask.
- R3: A write to offset 0x010 clears each enable bit where the data holds a one. A read of 0x010 returns the bitwise inverse of the mask.
- R4: The wake mask uses offset 0x014 to set, 0x018 to clear and 0x018 to read back inverted, following the rules of R2 and R3. It never influences `irq_o`.
- R5: Status bit i (read at 0x008) equals `port_irq[i]` as sampled on the previous clock edge. Writes to 0x000, 0x004 and 0x008 change nothing.
- R6: `irq_o` is a register. After each edge it equals the OR of (status AND enable) over the values updated at that edge. This includes an edge at which a port request and an enable write change together.
- R7: For addresses at or above 0x1000, the port index is (addr-0x1000)/0x200 and the local offset is the remainder. An access to a valid port with local offset below 0x100 drives, in the same cycle, `port_sel` one-hot at that index, `port_off`, `port_wdata`, and `port_wr` on a write or `port_rd` on a read. No other access raises any strobe.
- R8: Every read gets `bus_rvalid` high for exactly the following cycle. `bus_rdata` then holds the addressed value, and a forwarded read returns the selected port's `port_rdata` as sampled in the access cycle. Writes give no response.
- R9: Local offsets 0x100 to 0x1FF inside a port window are the DMA area. Writes there are discarded, and reads there return zero.
- R10: A port index not below NPORT gives no strobes and reads as zero. Unmapped global offsets read as zero, and writes to them change nothing.
- R11: While reset is applied, the status word, both masks and `irq_o` are zero and `port_rst` is high. `port_rst` falls within a few clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DW | Write data |
| bus_rvalid | output | 1 | Read response valid, one cycle after a read |
| bus_rdata | output | DW | Read response data |
| irq_o | output | 1 | Level interrupt to the host |
| port_rst | output | 1 | Reset pulse to all ports |
| port_sel | output | NPORT | One-hot port select |
| port_off | output | 9 | Local register offset |
| port_wdata | output | DW | Write data to the port |
| port_wr | output | 1 | Port write strobe |
| port_rd | output | 1 | Port read strobe |
| port_rdata | input | NPORT*DW | Read data from each port, packed by index |
| port_irq | input | NPORT | Interrupt request level from each port |

## Verification
The bench builds the hub with NPORT = 12 and the default 14-bit address.

With 12 ports, windows 12 to 15 fall inside the decoded range but belong to no port. The decoder can also form indices up to 23, which lie above the largest legal port count. Both kinds of out-of-range index are therefore reachable.

A model port bank answers reads with a value built from its own index and the local offset. This exposes a wrong port choice as well as a wrong offset. It also lets the bench check the count register against a value other than the default.

// File: rtl/hub_pkg.sv
package hub_pkg;

  localparam logic [31:0] HUB_ID_WORD  = 32'h0007_0002;
  localparam int          GLB_LIMIT    = 'h1000;
  localparam int          WIN_LG2      = 9;
  localparam int          OFF_W        = 9;

  localparam int OFS_ID     = 'h00;
  localparam int OFS_CNT    = 'h04;
  localparam int OFS_STS    = 'h08;
  localparam int OFS_EN_SET = 'h0C;
  localparam int OFS_EN_CLR = 'h10;
  localparam int OFS_WK_SET = 'h14;
  localparam int OFS_WK_CLR = 'h18;

  typedef enum logic [2:0] {
    GR_ID, GR_CNT, GR_STS, GR_ENS, GR_ENC, GR_WKS, GR_WKC, GR_NONE
  } greg_e;

  typedef struct packed {
    logic  glb;
    logic  fwd;
    greg_e greg;
  } hub_acc_t;

endpackage

// File: rtl/hub_decode.sv
module hub_decode
  import hub_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int NPORT  = 16,
  localparam int IDX_W = ADDR_W - WIN_LG2
) (
  input  logic [ADDR_W-1:0] addr,
  output hub_acc_t          acc,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off
);

  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(GLB_LIMIT);
  localparam logic [IDX_W:0]    NP_I    = (IDX_W+1)'(NPORT);

  logic [ADDR_W-1:0] rel;

  always_comb begin
    rel      = addr - LIMIT_A;
    idx      = rel[ADDR_W-1:WIN_LG2];
    off      = rel[OFF_W-1:0];
    acc.glb  = (addr < LIMIT_A);
    acc.fwd  = !acc.glb && ({1'b0, idx} < NP_I) && !off[OFF_W-1];
    acc.greg = GR_NONE;
    if (acc.glb) begin
      case (addr)
        ADDR_W'(OFS_ID):     acc.greg = GR_ID;
        ADDR_W'(OFS_CNT):    acc.greg = GR_CNT;
        ADDR_W'(OFS_STS):    acc.greg = GR_STS;
        ADDR_W'(OFS_EN_SET): acc.greg = GR_ENS;
        ADDR_W'(OFS_EN_CLR): acc.greg = GR_ENC;
        ADDR_W'(OFS_WK_SET): acc.greg = GR_WKS;
        ADDR_W'(OFS_WK_CLR): acc.greg = GR_WKC;
        default:             acc.greg = GR_NONE;
      endcase
    end
  end

endmodule

// File: rtl/hub_gregs.sv
module hub_gregs
  import hub_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  greg_e            greg,
  input  logic [DW-1:0]    wdata,
  input  logic [NPORT-1:0] port_irq,
  output logic [NPORT-1:0] sts_q,
  output logic [DW-1:0]    en_q,
  output logic [DW-1:0]    wk_q,
  output logic             irq_q
);

  logic [DW-1:0] en_d, wk_d;
  logic          irq_d;

  always_comb begin
    en_d = en_q;
    wk_d = wk_q;
    if (wr_en) begin
      case (greg)
        GR_ENS:  en_d = en_q | wdata;
        GR_ENC:  en_d = en_q & ~wdata;
        GR_WKS:  wk_d = wk_q | wdata;
        GR_WKC:  wk_d = wk_q & ~wdata;
        default: ;
      endcase
    end
    irq_d = |(port_irq & en_d[NPORT-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      wk_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= port_irq;
      irq_q <= irq_d;
      if (wr_en) begin
        en_q <= en_d;
        wk_q <= wk_d;
      end
    end
  end

endmodule

// File: rtl/hub_resp.sv
module hub_resp
  import hub_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int DW    = 32,
  parameter int IDX_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  hub_acc_t            acc,
  input  logic [IDX_W-1:0]    idx,
  input  logic [NPORT*DW-1:0] port_rdata,
  input  logic [NPORT-1:0]    sts,
  input  logic [DW-1:0]       en,
  input  logic [DW-1:0]       wk,
  output logic                rvalid,
  output logic [DW-1:0]       rdata
);

  logic [DW-1:0] port_pick, glb_val, rdata_d;

  always_comb begin
    port_pick = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (idx == IDX_W'(i)) port_pick = port_rdata[i*DW +: DW];
    end
  end

  always_comb begin
    case (acc.greg)
      GR_ID:   glb_val = DW'(HUB_ID_WORD);
      GR_CNT:  glb_val = DW'(NPORT);
      GR_STS:  glb_val = DW'(sts);
      GR_ENS:  glb_val = en;
      GR_ENC:  glb_val = ~en;
      GR_WKS:  glb_val = wk;
      GR_WKC:  glb_val = ~wk;
      default: glb_val = '0;
    endcase
    if (acc.glb)      rdata_d = glb_val;
    else if (acc.fwd) rdata_d = port_pick;
    else              rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/uart_irq_hub.sv
module uart_irq_hub
  import hub_pkg::*;
#(
  parameter int NPORT  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 14,
  localparam int IDX_W = ADDR_W - WIN_LG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                bus_rvalid,
  output logic [DW-1:0]       bus_rdata,
  output logic                irq_o,
  output logic                port_rst,
  output logic [NPORT-1:0]    port_sel,
  output logic [OFF_W-1:0]    port_off,
  output logic [DW-1:0]       port_wdata,
  output logic                port_wr,
  output logic                port_rd,
  input  logic [NPORT*DW-1:0] port_rdata,
  input  logic [NPORT-1:0]    port_irq
);

  logic [1:0]       rst_sync;
  logic             rst_s;
  hub_acc_t         acc;
  logic [IDX_W-1:0] idx;
  logic [OFF_W-1:0] off;
  logic [NPORT-1:0] sts_q;
  logic [DW-1:0]    en_q, wk_q;
  logic             fwd_go, glb_wr, rd_go;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) port_rst <= 1'b1;
    else        port_rst <= 1'b0;
  end

  hub_decode #(.ADDR_W(ADDR_W), .NPORT(NPORT)) u_dec (
    .addr (bus_addr),
    .acc  (acc),
    .idx  (idx),
    .off  (off)
  );

  assign fwd_go = bus_sel && acc.fwd;
  assign glb_wr = bus_sel && bus_we && acc.glb;
  assign rd_go  = bus_sel && !bus_we;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_sel
      assign port_sel[g] = fwd_go && (idx == IDX_W'(g));
    end
  endgenerate

  assign port_off   = off;
  assign port_wdata = bus_wdata;
  assign port_wr    = fwd_go && bus_we;
  assign port_rd    = fwd_go && !bus_we;

  hub_gregs #(.NPORT(NPORT), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_en    (glb_wr),
    .greg     (acc.greg),
    .wdata    (bus_wdata),
    .port_irq (port_irq),
    .sts_q    (sts_q),
    .en_q     (en_q),
    .wk_q     (wk_q),
    .irq_q    (irq_o)
  );

  hub_resp #(.NPORT(NPORT), .DW(DW), .IDX_W(IDX_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_s),
    .rd_en      (rd_go),
    .acc        (acc),
    .idx        (idx),
    .port_rdata (port_rdata),
    .sts        (sts_q),
    .en         (en_q),
    .wk         (wk_q),
    .rvalid     (bus_rvalid),
    .rdata      (bus_rdata)
  );

endmodule

// File: rtl/uart_irq_hub_chk.sv
module uart_irq_hub_chk #(
  parameter int NPORT  = 16,
  parameter int DW     = 32,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              irq_o,
  input logic              port_rst,
  input logic [NPORT-1:0]  port_sel,
  input logic              port_wr,
  input logic              port_rd,
  input logic [NPORT-1:0]  port_irq,
  input logic [NPORT-1:0]  sts_q,
  input logic [DW-1:0]     en_q
);

  logic [ADDR_W-1:0] rel;
  logic              in_dma;
  assign rel    = bus_addr - ADDR_W'('h1000);
  assign in_dma = (bus_addr >= ADDR_W'('h1000)) && rel[8];

  AST_STS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sts_q == $past(port_irq))); // R5
  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(sts_q & en_q[NPORT-1:0])); // R6
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_sel)); // R7
  AST_STROBE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr || port_rd) == (port_sel != '0)); // R7
  AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_wr && port_rd)); // R7
  AST_RVALID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |=> bus_rvalid); // R8
  AST_RVALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> !bus_rvalid); // R8
  AST_DMA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && in_dma) |-> (port_sel == '0)); // R9
  AST_RST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !port_rst); // R11

endmodule

bind uart_irq_hub uart_irq_hub_chk #(.NPORT(NPORT), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_s),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .irq_o      (irq_o),
  .port_rst   (port_rst),
  .port_sel   (port_sel),
  .port_wr    (port_wr),
  .port_rd    (port_rd),
  .port_irq   (port_irq),
  .sts_q      (sts_q),
  .en_q       (en_q)
);

// File: tb/uart_irq_hub_tb.sv
module uart_irq_hub_tb;

  localparam int CLK_P  = 10;
  localparam int NP     = 12;
  localparam int DW     = 32;
  localparam int ADDR_W = 14;

  typedef struct packed {
    logic          rd;
    logic [NP-1:0] sel;
    logic [8:0]    off;
    logic [DW-1:0] data;
  } fwd_t;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                bus_sel, bus_we;
  logic [ADDR_W-1:0]   bus_addr;
  logic [DW-1:0]       bus_wdata;
  logic                bus_rvalid;
  logic [DW-1:0]       bus_rdata;
  logic                irq_o, port_rst;
  logic [NP-1:0]       port_sel;
  logic [8:0]          port_off;
  logic [DW-1:0]       port_wdata;
  logic                port_wr, port_rd;
  logic [NP*DW-1:0]    port_rdata;
  logic [NP-1:0]       port_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_rd_q[$];
  string         tag_rd_q[$];
  fwd_t          fwd_q[$];
  logic [DW-1:0] en_m, wk_m;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_hub #(.NPORT(NP), .DW(DW), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .port_rst(port_rst),
    .port_sel(port_sel), .port_off(port_off), .port_wdata(port_wdata),
    .port_wr(port_wr), .port_rd(port_rd), .port_rdata(port_rdata),
    .port_irq(port_irq)
  );

  // model port bank: value encodes its index and the local offset
  always_comb begin
    for (int i = 0; i < NP; i++)
      port_rdata[i*DW +: DW] = 32'hC0DE_0000 | (32'(i) << 12) | 32'(port_off);
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit fwd_ok(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a - ADDR_W'('h1000);
    return (a >= ADDR_W'('h1000)) && (int'(r >> 9) < NP) && (r[8:0] < 9'h100);
  endfunction

  function automatic logic [DW-1:0] port_val(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] r;
    r = a - ADDR_W'('h1000);
    return 32'hC0DE_0000 | (32'(r >> 9) << 12) | 32'(r[8:0]);
  endfunction

  function automatic fwd_t mk_fwd(input logic [ADDR_W-1:0] a, input logic rd, input logic [DW-1:0] d);
    fwd_t f;
    logic [ADDR_W-1:0] r;
    r = a - ADDR_W'('h1000);
    f.rd = rd;
    f.sel = NP'(1) << (r >> 9);
    f.off = r[8:0];
    f.data = d;
    return f;
  endfunction

  task automatic bus_rd(input logic [ADDR_W-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    if (fwd_ok(a)) fwd_q.push_back(mk_fwd(a, 1'b1, '0));
    exp_rd_q.push_back(exp);
    tag_rd_q.push_back(req);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic bus_wr_irq(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d, input logic [NP-1:0] irqv);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; port_irq = irqv;
    if (fwd_ok(a)) fwd_q.push_back(mk_fwd(a, 1'b0, d));
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    bus_wr_irq(a, d, port_irq);
  endtask

  task automatic set_irq(input logic [NP-1:0] v);
    @(negedge clk);
    port_irq = v;
    @(negedge clk);
  endtask

  // monitor: pops expected items as the hub produces results
  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n) begin
      if (bus_rvalid) begin
        if (exp_rd_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R8 actual=rvalid expected=no response");
        end else begin
          string t;
          logic [DW-1:0] e;
          e = exp_rd_q.pop_front();
          t = tag_rd_q.pop_front();
          check(t, bus_rdata, e);
        end
      end
      if (port_wr || port_rd) begin
        if (fwd_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R7 actual=strobe sel=%h off=%h expected=none", port_sel, port_off);
        end else begin
          fwd_t f;
          f = fwd_q.pop_front();
          check("R7 strobe kind", {31'd0, port_rd}, {31'd0, f.rd});
          check("R7 select", DW'(port_sel), DW'(f.sel));
          check("R7 offset", DW'(port_off), DW'(f.off));
          if (!f.rd) check("R7 wdata", port_wdata, f.data);
        end
      end
    end
  end

  initial begin
    #(CLK_P*100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [ADDR_W-1:0] A_ID = 14'h000, A_CNT = 14'h004, A_STS = 14'h008,
    A_ENS = 14'h00C, A_ENC = 14'h010, A_WKS = 14'h014, A_WKC = 14'h018;

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    port_irq = '0; en_m = '0; wk_m = '0;
    repeat (3) @(negedge clk);
    #(CLK_P/4);
    check("R11 irq in reset", DW'(irq_o), 0);
    check("R11 port_rst in reset", DW'(port_rst), 1);
    check("R11 rvalid in reset", DW'(bus_rvalid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #(CLK_P/4);
    check("R11 port_rst released", DW'(port_rst), 0);
    bus_rd(A_STS, 0, "R11 status reset");
    bus_rd(A_ENS, 0, "R11 enable reset");
    bus_rd(A_WKS, 0, "R11 wake reset");
    bus_rd(A_ENC, 32'hFFFF_FFFF, "R11 enable inverse reset");

    // R1
    bus_rd(A_ID, 32'h0007_0002, "R1 id");
    bus_rd(A_CNT, NP, "R1 count");

    // R2
    bus_wr(A_ENS, 32'h0000_0005); en_m |= 32'h5;
    bus_rd(A_ENS, en_m, "R2 set");
    bus_wr(A_ENS, 32'h8000_0100); en_m |= 32'h8000_0100;
    bus_rd(A_ENS, en_m, "R2 accumulate");

    // R3
    bus_wr(A_ENC, 32'h0000_0101); en_m &= ~32'h101;
    bus_rd(A_ENC, ~en_m, "R3 inverse");
    bus_rd(A_ENS, en_m, "R3 cleared");

    // R5 and R6: en has bit 2
    set_irq(12'h014);
    #(CLK_P/4);
    check("R6 irq on enabled request", DW'(irq_o), 1);
    bus_rd(A_STS, 32'h14, "R5 status follows");
    bus_wr(A_STS, 32'hFFFF_FFFF);
    bus_wr(A_ID, 32'h1234_5678);
    bus_wr(A_CNT, 32'h0);
    bus_rd(A_STS, 32'h14, "R5 status write ignored");
    bus_rd(A_ID, 32'h0007_0002, "R5 id write ignored");
    bus_rd(A_CNT, NP, "R5 count write ignored");

    bus_wr(A_ENC, 32'h4); en_m &= ~32'h4;
    #(CLK_P/4);
    check("R6 irq off after clear", DW'(irq_o), 0);
    bus_wr(A_ENS, 32'h10); en_m |= 32'h10;
    #(CLK_P/4);
    check("R6 irq on after set", DW'(irq_o), 1);
    // same edge: bit4 request drops while bit2 enabled; bit2 still requesting
    bus_wr_irq(A_ENS, 32'h4, 12'h004); en_m |= 32'h4;
    #(CLK_P/4);
    check("R6 simultaneous keep", DW'(irq_o), 1);
    // same edge: all requests drop while enabling bit 7
    bus_wr_irq(A_ENS, 32'h80, 12'h000); en_m |= 32'h80;
    #(CLK_P/4);
    check("R6 simultaneous drop", DW'(irq_o), 0);
    // same edge: request 11 rises while clearing all enables
    bus_wr_irq(A_ENC, 32'hFFFF_FFFF, 12'h800); en_m = '0;
    #(CLK_P/4);
    check("R6 simultaneous clear", DW'(irq_o), 0);

    // R4
    bus_wr(A_WKS, 32'h0000_0800); wk_m |= 32'h800;
    #(CLK_P/4);
    check("R4 wake no irq", DW'(irq_o), 0);
    bus_rd(A_WKS, wk_m, "R4 wake set");
    bus_rd(A_WKC, ~wk_m, "R4 wake inverse");
    bus_wr(A_WKC, 32'h0000_0800); wk_m &= ~32'h800;
    bus_rd(A_WKS, wk_m, "R4 wake clear");
    set_irq(12'h000);

    // R7 forwarding
    bus_wr(14'h1004, 32'hAAAA_0001);
    bus_wr(14'h1000 + 14'(5*'h200) + 14'h0FC, 32'h5555_0005);
    bus_wr(14'h1000 + 14'(11*'h200) + 14'h010, 32'h0B0B_000B);
    bus_rd(14'h1000 + 14'(3*'h200) + 14'h010, port_val(14'h1000 + 14'(3*'h200) + 14'h010), "R7 R8 port 3 read");
    bus_rd(14'h1000 + 14'(11*'h200) + 14'h0FC, port_val(14'h1000 + 14'(11*'h200) + 14'h0FC), "R7 R8 port 11 read");

    // R9 DMA area
    bus_wr(14'h1000 + 14'(2*'h200) + 14'h100, 32'hDEAD_BEEF);
    bus_rd(14'h1000 + 14'(7*'h200) + 14'h1FC, 0, "R9 dma read zero");

    // R10 out of range and unmapped
    bus_wr(14'h2800, 32'h1111_1111);
    bus_rd(14'h2800, 0, "R10 index 12 read");
    bus_rd(14'h3E04, 0, "R10 index 23 read");
    bus_rd(14'h01C, 0, "R10 unmapped global");
    bus_rd(14'h800, 0, "R10 unmapped global high");
    bus_wr(14'h01C, 32'hFFFF_FFFF);
    bus_rd(A_ENS, en_m, "R10 unmapped write ignored");

    repeat (4) @(negedge clk);
    #(CLK_P/4);
    check("R8 all reads answered", DW'(exp_rd_q.size()), 0);
    check("R7 all forwards seen", DW'(fwd_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule